// File: doc/BRIEF.md
# Round-Robin 3D Workgroup Dispatcher

This block distributes the workgroups of a three-dimensional grid over a set of compute units. A start pulse captures the grid extent and the workgroup extent for each axis. It clears the workgroup coordinates and arms the dispatcher. While work remains, the block checks one compute unit per clock in rotating order. If that unit is ready, it is granted the next workgroup. The grant is a one-cycle, one-hot strobe. It comes with the 3D coordinate and the flat sequence number of the workgroup handed out.

Units are examined in passes. A pass covers every unit at most once and starts wherever a persistent rotation pointer stands. The pointer moves on after every unit examined, whether or not that unit received work. At the end of each pass the block pulses a pass-end flag and reports whether anything was granted during the pass. Coordinates advance along X first, then Y, then Z. The grid is finished when the Z coordinate runs past its extent. That ends the current pass at once and raises the done flag. All grid and workgroup extents must be nonzero.

Top module: `wgd_dispatcher`

## Requirements
- R1: After reset, no dispatch strobe and no pass-end pulse is asserted, and done_o is 1.
- R2: While work remains, exactly one unit is examined per clock: the unit at the rotation pointer. The pointer then moves to the next unit modulo NUM_CU, whether or not that unit was granted. The pointer is reset to unit 0 and is not changed by start_i.
- R3: A unit is granted only if ready_i for that unit was 1 at the examining edge and work remained. disp_o has at most one bit set, and bit k names unit k.
- R4: With each grant, the flat ID increases by one and the X coordinate increases by one. When the new X times the X workgroup size is at least the X grid size, X returns to 0 and Y increases. The same rule carries Y into Z. The first workgroup is (0,0,0) with flat ID 0.
- R5: When the Z coordinate would overflow by the same rule, work-remaining clears. done_o reads 1 from the next cycle, and no further grant occurs until the next start.
- R6: A pass ends after NUM_CU units have been examined, or on the grant that finishes the grid, whichever comes first. pass_end_o pulses for one cycle, aligned with the strobe of that last examination. pass_hit_o is 1 in that cycle exactly when the pass granted at least one workgroup, and it is 0 in every other cycle.
- R7: start_i loads all six extents, clears the coordinates and the flat ID, sets work-remaining and begins a fresh pass. No unit is examined in the cycle start_i is sampled. start_i takes effect even while a grid is still in progress.
- R8: The dispatch strobe lasts one cycle. wg_x_o, wg_y_o, wg_z_o and wg_flat_o carry the granted workgroup's ID in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load extents and begin a new grid |
| grid_x_i | input | DIM_W | Grid extent along X |
| grid_y_i | input | DIM_W | Grid extent along Y |
| grid_z_i | input | DIM_W | Grid extent along Z |
| wgsz_x_i | input | DIM_W | Workgroup extent along X |
| wgsz_y_i | input | DIM_W | Workgroup extent along Y |
| wgsz_z_i | input | DIM_W | Workgroup extent along Z |
| ready_i | input | NUM_CU | Per-unit ready flags |
| disp_o | output | NUM_CU | One-hot dispatch strobe |
| wg_x_o | output | DIM_W | X coordinate of the granted workgroup |
| wg_y_o | output | DIM_W | Y coordinate of the granted workgroup |
| wg_z_o | output | DIM_W | Z coordinate of the granted workgroup |
| wg_flat_o | output | 3*DIM_W | Flat sequence number of the granted workgroup |
| pass_end_o | output | 1 | One-cycle pulse at the end of a pass |
| pass_hit_o | output | 1 | The ending pass granted at least one workgroup |
| done_o | output | 1 | No workgroups remain |

## Verification
Two events can land in the same cycle. One is the grant of the grid's last workgroup. The other is the end of a pass, which happens either because that grant finishes the grid partway through the rotation or because the unit granted is the last one the pass examines. The sweep covers every grid of up to 3x3x2 with workgroup extents of 1 or 2. Readiness is all-ready, a single ready unit, or pseudo-random, so the final grant falls at every pass position. An arithmetic model in the bench predicts the strobe, pass-end, pass-hit and done values for each cycle. Every cycle's outputs are compared against that model.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
    localparam int NDIM = 3;
    typedef enum int {AX_X = 0, AX_Y = 1, AX_Z = 2} axis_e;
endpackage

// File: rtl/wgd_axis_step.sv
module wgd_axis_step #(
    parameter int DIM_W = 8
) (
    input  logic [DIM_W-1:0] idx_i,
    input  logic [DIM_W-1:0] wsz_i,
    input  logic [DIM_W-1:0] grid_i,
    input  logic             inc_i,
    output logic [DIM_W-1:0] idx_o,
    output logic             carry_o
);
    logic [DIM_W:0]     bumped;
    logic [2*DIM_W:0]   covered;

    always_comb begin
        bumped  = {1'b0, idx_i} + (DIM_W+1)'(1);
        covered = (2*DIM_W+1)'(bumped) * (2*DIM_W+1)'(wsz_i);
        idx_o   = idx_i;
        carry_o = 1'b0;
        if (inc_i) begin
            if (covered >= (2*DIM_W+1)'(grid_i)) begin
                idx_o   = '0;
                carry_o = 1'b1;
            end else begin
                idx_o = bumped[DIM_W-1:0];
            end
        end
    end
endmodule

// File: rtl/wgd_rr_pick.sv
module wgd_rr_pick #(
    parameter int NUM_CU = 4,
    parameter int PTR_W  = 2
) (
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [NUM_CU-1:0] ready_i,
    output logic [NUM_CU-1:0] sel_o,
    output logic              rdy_o,
    output logic [PTR_W-1:0]  ptr_nx_o
);
    always_comb begin
        sel_o = '0;
        for (int k = 0; k < NUM_CU; k++) begin
            if (ptr_i == PTR_W'(k)) sel_o[k] = 1'b1;
        end
        rdy_o    = |(sel_o & ready_i);
        ptr_nx_o = (ptr_i == PTR_W'(NUM_CU-1)) ? '0 : ptr_i + PTR_W'(1);
    end
endmodule

// File: rtl/wgd_dispatcher.sv
module wgd_dispatcher
    import wgd_pkg::*;
#(
    parameter  int NUM_CU = 4,
    parameter  int DIM_W  = 8,
    localparam int FLAT_W = 3*DIM_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [DIM_W-1:0]  grid_x_i,
    input  logic [DIM_W-1:0]  grid_y_i,
    input  logic [DIM_W-1:0]  grid_z_i,
    input  logic [DIM_W-1:0]  wgsz_x_i,
    input  logic [DIM_W-1:0]  wgsz_y_i,
    input  logic [DIM_W-1:0]  wgsz_z_i,
    input  logic [NUM_CU-1:0] ready_i,
    output logic [NUM_CU-1:0] disp_o,
    output logic [DIM_W-1:0]  wg_x_o,
    output logic [DIM_W-1:0]  wg_y_o,
    output logic [DIM_W-1:0]  wg_z_o,
    output logic [FLAT_W-1:0] wg_flat_o,
    output logic              pass_end_o,
    output logic              pass_hit_o,
    output logic              done_o
);
    localparam int PTR_W = (NUM_CU > 1) ? $clog2(NUM_CU) : 1;

    typedef logic [NDIM-1:0][DIM_W-1:0] vec3_t;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  cnt;
        logic              hit;
        logic              rem;
        vec3_t             grid;
        vec3_t             wsz;
        vec3_t             idx;
        logic [FLAT_W-1:0] flat;
        logic [NUM_CU-1:0] disp;
        vec3_t             oidx;
        logic [FLAT_W-1:0] oflat;
        logic              pend;
        logic              phit;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_CU-1:0] sel;
    logic              sel_rdy;
    logic [PTR_W-1:0]  ptr_nx;
    logic              grant;
    logic [NDIM:0]     carry;
    vec3_t             idx_nx;

    wgd_rr_pick #(.NUM_CU(NUM_CU), .PTR_W(PTR_W)) u_pick (
        .ptr_i    (s_q.ptr),
        .ready_i  (ready_i),
        .sel_o    (sel),
        .rdy_o    (sel_rdy),
        .ptr_nx_o (ptr_nx)
    );

    assign grant    = s_q.rem & ~start_i & sel_rdy;
    assign carry[0] = grant;

    for (genvar d = 0; d < NDIM; d++) begin : g_axis
        wgd_axis_step #(.DIM_W(DIM_W)) u_step (
            .idx_i   (s_q.idx[d]),
            .wsz_i   (s_q.wsz[d]),
            .grid_i  (s_q.grid[d]),
            .inc_i   (carry[d]),
            .idx_o   (idx_nx[d]),
            .carry_o (carry[d+1])
        );
    end

    always_comb begin
        logic fin;
        logic last;
        s_d      = s_q;
        s_d.disp = '0;
        s_d.pend = 1'b0;
        s_d.phit = 1'b0;
        fin      = carry[NDIM];
        last     = (s_q.cnt == PTR_W'(NUM_CU-1)) | fin;
        if (start_i) begin
            s_d.grid[AX_X] = grid_x_i;
            s_d.grid[AX_Y] = grid_y_i;
            s_d.grid[AX_Z] = grid_z_i;
            s_d.wsz[AX_X]  = wgsz_x_i;
            s_d.wsz[AX_Y]  = wgsz_y_i;
            s_d.wsz[AX_Z]  = wgsz_z_i;
            s_d.idx        = '0;
            s_d.flat       = '0;
            s_d.rem        = 1'b1;
            s_d.cnt        = '0;
            s_d.hit        = 1'b0;
        end else if (s_q.rem) begin
            s_d.ptr = ptr_nx;
            if (grant) begin
                s_d.disp  = sel;
                s_d.oidx  = s_q.idx;
                s_d.oflat = s_q.flat;
                s_d.idx   = idx_nx;
                s_d.flat  = s_q.flat + FLAT_W'(1);
            end
            s_d.pend = last;
            s_d.phit = last & (s_q.hit | grant);
            s_d.hit  = last ? 1'b0 : (s_q.hit | grant);
            s_d.cnt  = last ? '0 : s_q.cnt + PTR_W'(1);
            s_d.rem  = ~fin;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    assign disp_o     = s_q.disp;
    assign wg_x_o     = s_q.oidx[AX_X];
    assign wg_y_o     = s_q.oidx[AX_Y];
    assign wg_z_o     = s_q.oidx[AX_Z];
    assign wg_flat_o  = s_q.oflat;
    assign pass_end_o = s_q.pend;
    assign pass_hit_o = s_q.phit;
    assign done_o     = ~s_q.rem;

    // R3: strobe is one-hot or idle
    a_r3_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(disp_o));

    // R3: a granted unit was ready at the examining edge
    a_r3_ready_grant: assert property (@(posedge clk_i) disable iff (rst_i)
        (disp_o != '0) |-> (($past(ready_i) & disp_o) == disp_o));

    // R2: the pointer steps on every examined unit
    a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_q.rem && !start_i) |=>
        (s_q.ptr == (($past(s_q.ptr) == PTR_W'(NUM_CU-1)) ? '0 : $past(s_q.ptr) + PTR_W'(1))));

    // R5: nothing is granted once the grid is finished
    a_r5_idle_when_done: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !start_i) |=> (disp_o == '0));

    // R4: flat counter advances by one per grant
    a_r4_flat_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (disp_o != '0) |-> (s_q.flat == $past(s_q.flat) + FLAT_W'(1)));

    // R6: pass-hit only accompanies a pass-end pulse
    a_r6_hit_with_end: assert property (@(posedge clk_i) disable iff (rst_i)
        !pass_end_o |-> !pass_hit_o);
endmodule

// File: tb/wgd_dispatcher_tb.sv
module wgd_dispatcher_tb;
    localparam int N       = 3;
    localparam int DW      = 4;
    localparam int FW      = 3*DW;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] gx = '0, gy = '0, gz = '0, wx = '0, wy = '0, wz = '0;
    logic [N-1:0]  rdy = '0;
    logic [N-1:0]  disp;
    logic [DW-1:0] ox, oy, oz;
    logic [FW-1:0] oflat;
    logic          pend, phit, done;

    int errors = 0;
    int checks = 0;

    // model state
    int m_ptr = 0, m_cnt = 0, m_hit = 0, m_rem = 0, m_flat = 0;
    int m_g[3], m_w[3], m_i[3];
    int e_disp = 0, e_x = 0, e_y = 0, e_z = 0, e_flat = 0, e_pend = 0, e_phit = 0;
    int grants = 0;
    int lfsr = 32'h1d3;

    always #(CLK_PER/2) clk = ~clk;

    wgd_dispatcher #(.NUM_CU(N), .DIM_W(DW)) u_dut (
        .clk_i(clk), .rst_i(rst), .start_i(start),
        .grid_x_i(gx), .grid_y_i(gy), .grid_z_i(gz),
        .wgsz_x_i(wx), .wgsz_y_i(wy), .wgsz_z_i(wz),
        .ready_i(rdy), .disp_o(disp),
        .wg_x_o(ox), .wg_y_o(oy), .wg_z_o(oz), .wg_flat_o(oflat),
        .pass_end_o(pend), .pass_hit_o(phit), .done_o(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R3 strobe", int'(disp), e_disp);
        chk("R6 pass_end", int'(pend), e_pend);
        chk("R6 pass_hit", int'(phit), e_phit);
        chk("R5 done", int'(done), m_rem ? 0 : 1);
        if (e_disp != 0) begin
            chk("R8 wg_x", int'(ox), e_x);
            chk("R8 wg_y", int'(oy), e_y);
            chk("R4 wg_z", int'(oz), e_z);
            chk("R4 wg_flat", int'(oflat), e_flat);
        end
    endtask

    // compare previous cycle, then drive and predict the next edge
    task automatic tick(input logic st, input logic [N-1:0] r);
        int fin;
        int last;
        int g;
        @(negedge clk);
        compare();
        start = st;
        rdy   = r;
        e_disp = 0; e_pend = 0; e_phit = 0;
        if (st) begin
            m_g[0] = int'(gx); m_g[1] = int'(gy); m_g[2] = int'(gz);
            m_w[0] = int'(wx); m_w[1] = int'(wy); m_w[2] = int'(wz);
            m_i[0] = 0; m_i[1] = 0; m_i[2] = 0;
            m_flat = 0; m_rem = 1; m_cnt = 0; m_hit = 0;
        end else if (m_rem != 0) begin
            g   = int'(r[m_ptr]);
            fin = 0;
            if (g != 0) begin
                grants++;
                e_disp = 1 << m_ptr;
                e_x = m_i[0]; e_y = m_i[1]; e_z = m_i[2]; e_flat = m_flat;
                m_flat++;
                m_i[0]++;
                if (m_i[0] * m_w[0] >= m_g[0]) begin
                    m_i[0] = 0; m_i[1]++;
                    if (m_i[1] * m_w[1] >= m_g[1]) begin
                        m_i[1] = 0; m_i[2]++;
                        if (m_i[2] * m_w[2] >= m_g[2]) begin
                            m_i[2] = 0; fin = 1;
                        end
                    end
                end
            end
            last   = (m_cnt == N-1 || fin != 0) ? 1 : 0;
            e_pend = last;
            e_phit = last ? ((m_hit | g) != 0 ? 1 : 0) : 0;
            m_hit  = last ? 0 : (m_hit | g);
            m_cnt  = last ? 0 : m_cnt + 1;
            m_ptr  = (m_ptr + 1) % N;
            m_rem  = fin ? 0 : 1;
        end
    endtask

    function automatic logic [N-1:0] pattern(input int mode, input int sel);
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'h80200003 : 0);
        case (mode)
            0:       return '1;
            1:       return N'(1 << sel);
            default: return N'(lfsr);
        endcase
    endfunction

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cfg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 strobe", int'(disp), 0);
        chk("R1 pass_end", int'(pend), 0);
        chk("R1 done", int'(done), 1);
        rst = 1'b0;
        tick(1'b0, '1);   // R5: no grant while idle after reset

        // R2: all ready, rotation starts at unit 0 and covers every unit
        gx = 4'd5; gy = 4'd1; gz = 4'd1; wx = 4'd1; wy = 4'd1; wz = 4'd1;
        tick(1'b1, '1);
        for (int k = 0; k < 6; k++) tick(1'b0, '1);

        // R2 pointer moves past unready units; R7 restart mid-grid keeps pointer
        gx = 4'd3; gy = 4'd3; gz = 4'd2;
        tick(1'b1, '0);
        tick(1'b0, 3'b000);
        tick(1'b0, 3'b100);
        tick(1'b0, 3'b011);
        tick(1'b0, 3'b010);
        gx = 4'd2; gy = 4'd2; gz = 4'd1;
        tick(1'b1, '1);          // R7: no grant in the start cycle
        for (int k = 0; k < 8; k++) tick(1'b0, 3'b101);

        // sweep of grids and workgroup extents
        for (int ax = 1; ax <= 3; ax++)
        for (int ay = 1; ay <= 3; ay++)
        for (int az = 1; az <= 2; az++)
        for (int sx = 1; sx <= 2; sx++)
        for (int sy = 1; sy <= 2; sy++)
        for (int sz = 1; sz <= 2; sz++) begin
            int mode;
            int expect_wg;
            int guard;
            mode = cfg % 3;
            gx = DW'(ax); gy = DW'(ay); gz = DW'(az);
            wx = DW'(sx); wy = DW'(sy); wz = DW'(sz);
            tick(1'b1, pattern(mode, cfg % N));
            grants = 0;
            guard = 0;
            while (m_rem != 0 && guard < 400) begin
                tick(1'b0, pattern(mode, cfg % N));
                guard++;
            end
            tick(1'b0, '1);
            tick(1'b0, '1);
            expect_wg = cdiv(ax, sx) * cdiv(ay, sy) * cdiv(az, sz);
            chk("R4 R5 total workgroups", grants, expect_wg);
            cfg++;
        end
        tick(1'b0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule